// File: doc/BRIEF.md
# Ethernet DMA Control and Status Register Unit

This block is the register bank that sits in front of the DMA engine of a multi-ring Ethernet controller. A simple word bus reads and writes 32-bit registers. Behind them sit an interrupt event register with its mask, per-ring halt flags that double as restart triggers, per-ring descriptor base and current-pointer registers, and a DMA control register. Three registered interrupt lines leave the block, one each for the transmit, receive and error event groups.

The unit does not walk descriptor rings. It sends single-cycle restart pulses per ring and a periodic "scan transmit ring 0" pulse to an external ring engine. That engine reports back halted rings, frame-in-progress levels, frame-end pulses and raw event bits. A graceful stop request completes at once when no frame is in flight. Otherwise it completes on the frame-end pulse.

Top module: `eth_dma_csr`

## Requirements
- R1: An access takes effect only when `bus_valid` is high, `bus_be` is 4'b1111 and `bus_addr[1:0]` is 0. The word index is `bus_addr[7:2]`. Any other write changes nothing, and any other read returns 0.
- R2: After reset every register reads 0. Word indices that hold no register read 0, and writes to them are ignored.
- R3: Event register (byte 0x00) bits are cleared by writing 1. A bit set internally in the same cycle as a clear of that bit stays set.
- R4: The mask register is at byte 0x04. `irq_tx` is the OR of (event AND mask) bits 7:0, `irq_rx` of bits 15:8 and `irq_err` of bits 31:16. All three are registered and change on the same clock edge as the event or mask register.
- R5: The transmit halt register is at byte 0x0C. Ring i uses bit 31-i, which `tx_halt_set[i]` sets. Writing 1 to that bit clears it and pulses `tx_restart[i]` for one cycle in the cycle after the write.
- R6: The receive halt register is at byte 0x10. Ring i uses bit 23-i, which `rx_halt_set[i]` sets. Writing 1 clears the bit. `rx_restart[i]` pulses in the cycle after the write only when the written bit is 1 and the stored flag was 0.
- R7: Transmit base i is at byte 0x40+4i, transmit pointer i at 0x60+4i, receive base i at 0x80+4i and receive pointer i at 0xA0+4i. Stored values have bits 2:0 forced to 0. A base write also loads the same aligned value into that ring's pointer.
- R8: Control register (byte 0x08) bit 3 requests a graceful receive stop and bit 4 a graceful transmit stop. A control write with bit 3 set and `rx_frame_busy` low sets event bit 8 at that write's clock edge. Bit 4 does the same with `tx_frame_busy` and event bit 0.
- R9: If the matching frame-busy input is high at the stop request, the event bit is not set. It is set on the edge where the one-cycle frame-end pulse arrives.
- R10: A control write with bit 6 (wait-on-poll) clear arms a timer of POLL_CYCLES cycles. Each expiry produces a one-cycle `tx_poll` pulse POLL_CYCLES edges after the arming edge, then re-arms. While bit 4 is set, expiries re-arm but give no pulse. If bit 6 is set at expiry, the timer stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_be | input | 4 | Byte enables, must be all ones |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| evt_set_in | input | 32 | Event bits raised by the ring engine |
| tx_halt_set | input | 8 | Transmit ring halted, per ring |
| rx_halt_set | input | 8 | Receive ring halted, per ring |
| tx_frame_busy | input | 1 | Transmit frame in progress |
| tx_frame_end | input | 1 | Transmit frame finished, one-cycle pulse |
| rx_frame_busy | input | 1 | Receive frame in progress |
| rx_frame_end | input | 1 | Receive frame finished, one-cycle pulse |
| tx_restart | output | 8 | Per-ring transmit restart pulse |
| rx_restart | output | 8 | Per-ring receive restart pulse |
| tx_poll | output | 1 | Scan transmit ring 0 pulse |
| irq_tx | output | 1 | Transmit group interrupt |
| irq_rx | output | 1 | Receive group interrupt |
| irq_err | output | 1 | Error group interrupt |

## Verification
The bench writes a receive halt word in which one bit names a flag that is set and another names a flag that is clear. Only the clear ring may restart, so a design that restarts on every written 1 emits the wrong ring mask. An event clear and an internal set are aimed at the same bit in one cycle; a design that lets the clear win loses the error interrupt. A graceful transmit stop is requested while a frame is busy; a design that completes at once raises the event before the frame-end pulse. The poll timer is timed to the exact edge and is also run with graceful transmit stop set and with wait-on-poll set, so an off-by-one period, or a timer that ignores those bits, changes the pulse count.

// File: rtl/eth_dma_csr_pkg.sv
package eth_dma_csr_pkg;
  localparam int unsigned DW         = 32;
  // word indices of the register bank
  localparam int unsigned IDX_EVT    = 0;
  localparam int unsigned IDX_MSK    = 1;
  localparam int unsigned IDX_CTL    = 2;
  localparam int unsigned IDX_TST    = 3;
  localparam int unsigned IDX_RST    = 4;
  localparam int unsigned IDX_TBASE  = 16;
  localparam int unsigned IDX_TPTR   = 24;
  localparam int unsigned IDX_RBASE  = 32;
  localparam int unsigned IDX_RPTR   = 40;
  // interrupt groups of the event register
  localparam logic [DW-1:0] GRP_TX   = 32'h0000_00FF;
  localparam logic [DW-1:0] GRP_RX   = 32'h0000_FF00;
  localparam logic [DW-1:0] GRP_ERR  = 32'hFFFF_0000;
  localparam int unsigned EV_TX_STOP = 0;
  localparam int unsigned EV_RX_STOP = 8;
  // control register fields
  localparam int unsigned CTL_GRS    = 3;
  localparam int unsigned CTL_GTS    = 4;
  localparam int unsigned CTL_WOP    = 6;
  localparam logic [DW-1:0] CTL_MASK = 32'h0000_0058;
  // halt register layout: ring i at TOP-i
  localparam int unsigned TST_TOP    = 31;
  localparam int unsigned RST_TOP    = 23;
  localparam logic [DW-1:0] ALIGN_M  = 32'hFFFF_FFF8;
endpackage

// File: rtl/eth_dma_irq.sv
module eth_dma_irq
  import eth_dma_csr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_we,
  input  logic          msk_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt_set,
  output logic [DW-1:0] evt_q,
  output logic [DW-1:0] msk_q,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          irq_err
);
  logic [DW-1:0] evt_d, msk_d, act_d;

  always_comb begin
    evt_d = evt_q;
    if (evt_we) evt_d = evt_q & ~wdata;
    evt_d = evt_d | evt_set;             // set wins over clear
    msk_d = msk_we ? wdata : msk_q;
    act_d = evt_d & msk_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q   <= '0;
      msk_q   <= '0;
      irq_tx  <= 1'b0;
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      evt_q   <= evt_d;
      msk_q   <= msk_d;
      irq_tx  <= |(act_d & GRP_TX);
      irq_rx  <= |(act_d & GRP_RX);
      irq_err <= |(act_d & GRP_ERR);
    end
  end
endmodule

// File: rtl/eth_dma_gstop.sv
module eth_dma_gstop (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic frame_busy,
  input  logic frame_end,
  output logic done,
  output logic pend_q
);
  logic pend_d;

  always_comb begin
    done   = (stop_req && !frame_busy) || (pend_q && frame_end);
    pend_d = pend_q;
    if (done)                        pend_d = 1'b0;
    else if (stop_req && frame_busy) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/eth_dma_poll.sv
module eth_dma_poll #(
  parameter int unsigned PERIOD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic wop,
  input  logic gts,
  output logic poll
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, poll_d;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    poll_d = 1'b0;
    if (arm) begin
      run_d = 1'b1;
      cnt_d = RELOAD;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        if (wop) begin
          run_d = 1'b0;
        end else begin
          poll_d = !gts;
          cnt_d  = RELOAD;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      poll  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      poll  <= poll_d;
    end
  end
endmodule

// File: rtl/eth_dma_csr.sv
module eth_dma_csr
  import eth_dma_csr_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter int unsigned NRING       = 8,
  parameter int unsigned POLL_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [3:0]       bus_be,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [DW-1:0]    evt_set_in,
  input  logic [NRING-1:0] tx_halt_set,
  input  logic [NRING-1:0] rx_halt_set,
  input  logic             tx_frame_busy,
  input  logic             tx_frame_end,
  input  logic             rx_frame_busy,
  input  logic             rx_frame_end,
  output logic [NRING-1:0] tx_restart,
  output logic [NRING-1:0] rx_restart,
  output logic             tx_poll,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             irq_err
);
  localparam int unsigned IW = AW - 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  // decode
  logic          acc_ok, wr;
  logic [IW-1:0] widx;
  logic          wr_evt, wr_msk, wr_ctl, wr_tst, wr_rst;
  assign acc_ok = bus_valid && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
  assign wr     = acc_ok && bus_write;
  assign widx   = bus_addr[AW-1:2];
  assign wr_evt = wr && (widx == IW'(IDX_EVT));
  assign wr_msk = wr && (widx == IW'(IDX_MSK));
  assign wr_ctl = wr && (widx == IW'(IDX_CTL));
  assign wr_tst = wr && (widx == IW'(IDX_TST));
  assign wr_rst = wr && (widx == IW'(IDX_RST));

  // control, halt flags, restart pulses
  logic [DW-1:0]    ctl_q, ctl_d, tst_q, tst_d, rst_q, rst_d;
  logic [NRING-1:0] txr_d, rxr_d;

  always_comb begin
    ctl_d = wr_ctl ? (bus_wdata & CTL_MASK) : ctl_q;
    tst_d = wr_tst ? (tst_q & ~bus_wdata) : tst_q;
    rst_d = wr_rst ? (rst_q & ~bus_wdata) : rst_q;
    for (int i = 0; i < NRING; i++) begin
      if (tx_halt_set[i]) tst_d[TST_TOP-i] = 1'b1;
      if (rx_halt_set[i]) rst_d[RST_TOP-i] = 1'b1;
      txr_d[i] = wr_tst && bus_wdata[TST_TOP-i];
      rxr_d[i] = wr_rst && bus_wdata[RST_TOP-i] && !rst_q[RST_TOP-i];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctl_q      <= '0;
      tst_q      <= '0;
      rst_q      <= '0;
      tx_restart <= '0;
      rx_restart <= '0;
    end else begin
      ctl_q      <= ctl_d;
      tst_q      <= tst_d;
      rst_q      <= rst_d;
      tx_restart <= txr_d;
      rx_restart <= rxr_d;
    end
  end

  // descriptor base and pointer registers, one set per ring
  logic [NRING-1:0][DW-1:0] tbase_q, tptr_q, rbase_q, rptr_q;
  logic [DW-1:0]            wdata_al;
  assign wdata_al = bus_wdata & ALIGN_M;

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    logic wtb, wtp, wrb, wrp;
    assign wtb = wr && (widx == IW'(IDX_TBASE + g));
    assign wtp = wr && (widx == IW'(IDX_TPTR  + g));
    assign wrb = wr && (widx == IW'(IDX_RBASE + g));
    assign wrp = wr && (widx == IW'(IDX_RPTR  + g));
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) begin
        tbase_q[g] <= '0;
        tptr_q[g]  <= '0;
        rbase_q[g] <= '0;
        rptr_q[g]  <= '0;
      end else begin
        if (wtb)        tbase_q[g] <= wdata_al;
        if (wtb || wtp) tptr_q[g]  <= wdata_al;
        if (wrb)        rbase_q[g] <= wdata_al;
        if (wrb || wrp) rptr_q[g]  <= wdata_al;
      end
    end
  end

  // graceful stops
  logic tx_done, rx_done, tx_pend, rx_pend;
  eth_dma_gstop u_gstop_tx (
    .clk(clk), .rst_n(rst_n_s),
    .stop_req(wr_ctl && bus_wdata[CTL_GTS]),
    .frame_busy(tx_frame_busy), .frame_end(tx_frame_end),
    .done(tx_done), .pend_q(tx_pend)
  );
  eth_dma_gstop u_gstop_rx (
    .clk(clk), .rst_n(rst_n_s),
    .stop_req(wr_ctl && bus_wdata[CTL_GRS]),
    .frame_busy(rx_frame_busy), .frame_end(rx_frame_end),
    .done(rx_done), .pend_q(rx_pend)
  );

  // events and interrupts
  logic [DW-1:0] evt_q, msk_q, evt_set;
  always_comb begin
    evt_set = evt_set_in;
    evt_set[EV_TX_STOP] = evt_set_in[EV_TX_STOP] | tx_done;
    evt_set[EV_RX_STOP] = evt_set_in[EV_RX_STOP] | rx_done;
  end

  eth_dma_irq u_irq (
    .clk(clk), .rst_n(rst_n_s),
    .evt_we(wr_evt), .msk_we(wr_msk), .wdata(bus_wdata), .evt_set(evt_set),
    .evt_q(evt_q), .msk_q(msk_q),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  // poll timer
  eth_dma_poll #(.PERIOD(POLL_CYCLES)) u_poll (
    .clk(clk), .rst_n(rst_n_s),
    .arm(wr_ctl && !bus_wdata[CTL_WOP]),
    .wop(ctl_q[CTL_WOP]), .gts(ctl_q[CTL_GTS]),
    .poll(tx_poll)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (acc_ok && !bus_write) begin
      if (widx == IW'(IDX_EVT)) bus_rdata = evt_q;
      if (widx == IW'(IDX_MSK)) bus_rdata = msk_q;
      if (widx == IW'(IDX_CTL)) bus_rdata = ctl_q;
      if (widx == IW'(IDX_TST)) bus_rdata = tst_q;
      if (widx == IW'(IDX_RST)) bus_rdata = rst_q;
      for (int i = 0; i < NRING; i++) begin
        if (widx == IW'(IDX_TBASE + i)) bus_rdata = tbase_q[i];
        if (widx == IW'(IDX_TPTR  + i)) bus_rdata = tptr_q[i];
        if (widx == IW'(IDX_RBASE + i)) bus_rdata = rbase_q[i];
        if (widx == IW'(IDX_RPTR  + i)) bus_rdata = rptr_q[i];
      end
    end
  end
endmodule

// File: rtl/eth_dma_csr_chk.sv
module eth_dma_csr_chk
  import eth_dma_csr_pkg::*;
#(
  parameter int unsigned NRING = 8
) (
  input logic                     clk,
  input logic                     rst_n_s,
  input logic [DW-1:0]            evt_q,
  input logic [DW-1:0]            msk_q,
  input logic [DW-1:0]            ctl_q,
  input logic                     irq_tx,
  input logic                     irq_rx,
  input logic                     irq_err,
  input logic                     wr_tst,
  input logic                     wr_rst,
  input logic [NRING-1:0]         tx_restart,
  input logic [NRING-1:0]         rx_restart,
  input logic                     tx_pend,
  input logic                     tx_frame_end,
  input logic                     tx_poll,
  input logic [NRING-1:0][DW-1:0] tbase_q,
  input logic [NRING-1:0][DW-1:0] tptr_q,
  input logic [NRING-1:0][DW-1:0] rbase_q,
  input logic [NRING-1:0][DW-1:0] rptr_q
);
  // R4
  irq_groups_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_tx == |(evt_q & msk_q & GRP_TX)) && (irq_rx == |(evt_q & msk_q & GRP_RX))
    && (irq_err == |(evt_q & msk_q & GRP_ERR)));

  // R5
  tx_restart_src_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (|tx_restart) |-> $past(wr_tst));

  // R6
  rx_restart_src_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (|rx_restart) |-> $past(wr_rst));

  // R9
  tx_deferred_stop_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tx_pend && tx_frame_end) |=> evt_q[EV_TX_STOP]);

  // R10
  poll_gated_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    tx_poll |-> !$past(ctl_q[CTL_GTS]));

  // R10
  poll_single_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    tx_poll |=> !tx_poll);

  for (genvar g = 0; g < NRING; g++) begin : g_al
    // R7
    ring_align_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      (tbase_q[g][2:0] == 3'b0) && (tptr_q[g][2:0] == 3'b0)
      && (rbase_q[g][2:0] == 3'b0) && (rptr_q[g][2:0] == 3'b0));
  end
endmodule

bind eth_dma_csr eth_dma_csr_chk #(.NRING(NRING)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .evt_q(evt_q), .msk_q(msk_q), .ctl_q(ctl_q),
  .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err),
  .wr_tst(wr_tst), .wr_rst(wr_rst), .tx_restart(tx_restart), .rx_restart(rx_restart),
  .tx_pend(tx_pend), .tx_frame_end(tx_frame_end), .tx_poll(tx_poll),
  .tbase_q(tbase_q), .tptr_q(tptr_q), .rbase_q(rbase_q), .rptr_q(rptr_q)
);

// File: tb/eth_dma_csr_tb.sv
`timescale 1ns/1ps
module eth_dma_csr_tb;
  localparam int unsigned P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [7:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata, evt_set_in;
  logic [7:0]  tx_halt_set, rx_halt_set, tx_restart, rx_restart;
  logic        tx_frame_busy, tx_frame_end, rx_frame_busy, rx_frame_end;
  logic        tx_poll, irq_tx, irq_rx, irq_err;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  logic [7:0] cap_txr, cap_rxr;

  always #2.5 clk = ~clk;

  eth_dma_csr #(.AW(8), .NRING(8), .POLL_CYCLES(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_set_in(evt_set_in), .tx_halt_set(tx_halt_set), .rx_halt_set(rx_halt_set),
    .tx_frame_busy(tx_frame_busy), .tx_frame_end(tx_frame_end),
    .rx_frame_busy(rx_frame_busy), .rx_frame_end(rx_frame_end),
    .tx_restart(tx_restart), .rx_restart(rx_restart), .tx_poll(tx_poll),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk); #1;
    cap_txr = tx_restart; cap_rxr = rx_restart;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = be;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R2 irq after reset", {29'b0, irq_tx, irq_rx, irq_err}, 32'h0);
    check("R2 poll after reset", {31'b0, tx_poll}, 32'h0);
    bus_rd(8'h08, v); check("R2 control reset", v, 32'h0);
    bus_rd(8'h0C, v); check("R2 tx halt reset", v, 32'h0);
    bus_rd(8'h64, v); check("R2 tx pointer reset", v, 32'h0);
  endtask

  task automatic t_bases;
    logic [31:0] v;
    bus_wr(8'h4C, 32'h1234_567F);
    bus_rd(8'h4C, v); check("R7 tx base 3 aligned", v, 32'h1234_5678);
    bus_rd(8'h6C, v); check("R7 tx pointer 3 mirrored", v, 32'h1234_5678);
    bus_wr(8'h94, 32'hCAFE_0007);
    bus_rd(8'hB4, v); check("R7 rx pointer 5 mirrored", v, 32'hCAFE_0000);
    bus_wr(8'hB4, 32'h0000_0ABD);
    bus_rd(8'hB4, v); check("R7 rx pointer direct aligned", v, 32'h0000_0AB8);
    bus_rd(8'h94, v); check("R7 rx base unchanged", v, 32'hCAFE_0000);
  endtask

  task automatic t_tx_halt;
    logic [31:0] v;
    @(negedge clk); tx_halt_set = 8'b0000_0100;
    @(negedge clk); tx_halt_set = 8'h0;
    bus_rd(8'h0C, v); check("R5 ring 2 halt bit 29", v, 32'h2000_0000);
    bus_wr(8'h0C, 32'hA000_0000);
    check("R5 restart rings 0 and 2", {24'b0, cap_txr}, 32'h0000_0005);
    @(posedge clk); #1;
    check("R5 restart single cycle", {24'b0, tx_restart}, 32'h0);
    bus_rd(8'h0C, v); check("R5 halt cleared", v, 32'h0);
  endtask

  task automatic t_rx_halt;
    logic [31:0] v;
    @(negedge clk); rx_halt_set = 8'b0000_0010;
    @(negedge clk); rx_halt_set = 8'h0;
    bus_rd(8'h10, v); check("R6 ring 1 halt bit 22", v, 32'h0040_0000);
    bus_wr(8'h10, 32'h0050_0000);
    check("R6 restart only ring 3", {24'b0, cap_rxr}, 32'h0000_0008);
    bus_rd(8'h10, v); check("R6 halt cleared", v, 32'h0);
  endtask

  task automatic t_gstop_now;
    logic [31:0] v;
    bus_wr(8'h04, 32'h0001_0101);
    bus_wr(8'h08, 32'h0000_0048);
    check("R8 rx stop irq immediate", {31'b0, irq_rx}, 32'h1);
    bus_rd(8'h00, v); check("R8 event bit 8", v, 32'h0000_0100);
    bus_wr(8'h00, 32'h0000_0100);
    check("R3 clear drops irq_rx", {31'b0, irq_rx}, 32'h0);
  endtask

  task automatic t_gstop_defer;
    logic [31:0] v;
    tx_frame_busy = 1'b1;
    bus_wr(8'h08, 32'h0000_0050);
    check("R9 no irq while busy", {31'b0, irq_tx}, 32'h0);
    bus_rd(8'h00, v); check("R9 event held off", v, 32'h0);
    @(negedge clk); tx_frame_end = 1'b1; tx_frame_busy = 1'b0;
    @(posedge clk); #1;
    check("R9 irq at frame end", {31'b0, irq_tx}, 32'h1);
    @(negedge clk); tx_frame_end = 1'b0;
    bus_wr(8'h00, 32'h0000_0001);
    bus_wr(8'h08, 32'h0000_0040);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    @(negedge clk);
    evt_set_in = 32'h0001_0000;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0001_0000; bus_be = 4'hF;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0; evt_set_in = 32'h0;
    check("R4 irq_err from set", {31'b0, irq_err}, 32'h1);
    bus_rd(8'h00, v); check("R3 set wins over clear", v, 32'h0001_0000);
    bus_wr(8'h04, 32'h0000_0101);
    check("R4 mask off drops irq_err", {31'b0, irq_err}, 32'h0);
    bus_wr(8'h00, 32'h0001_0000);
  endtask

  task automatic t_access;
    logic [31:0] v;
    bus_wr(8'h14, 32'hDEAD_BEEF);
    bus_rd(8'h14, v); check("R2 unknown index reads 0", v, 32'h0);
    bus_wr(8'h04, 32'hFFFF_FFFF, 4'h3);
    bus_rd(8'h04, v); check("R1 partial write ignored", v, 32'h0000_0101);
    bus_wr(8'h06, 32'hFFFF_FFFF);
    bus_rd(8'h04, v); check("R1 misaligned write ignored", v, 32'h0000_0101);
    bus_rd(8'h04, v, 4'h1); check("R1 partial read returns 0", v, 32'h0);
  endtask

  task automatic count_polls(input int n, output int cnt, output int first);
    cnt = 0; first = -1;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); #1;
      if (tx_poll) begin
        cnt++;
        if (first < 0) first = k;
      end
    end
  endtask

  task automatic t_poll;
    int c, f;
    bus_wr(8'h08, 32'h0000_0000);
    count_polls(4*P, c, f);
    check("R10 first poll after period", f, P);
    check("R10 poll count", c, 4);
    bus_wr(8'h08, 32'h0000_0010);
    count_polls(3*P, c, f);
    check("R10 no poll with tx stop", c, 0);
    bus_wr(8'h08, 32'h0000_0000);
    bus_wr(8'h08, 32'h0000_0040);
    count_polls(3*P, c, f);
    check("R10 timer stops on wait-on-poll", c, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_valid = 0; bus_write = 0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    evt_set_in = '0; tx_halt_set = '0; rx_halt_set = '0;
    tx_frame_busy = 0; tx_frame_end = 0; rx_frame_busy = 0; rx_frame_end = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_bases();
    t_tx_halt();
    t_rx_halt();
    t_gstop_now();
    t_gstop_defer();
    t_priority();
    t_access();
    t_poll();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule